// File: doc/BRIEF.md
# Page-Buffered Asynchronous Read Controller

This block sits between a host read port and a slow memory array that is organised in pages of four words. When the host latches an address whose page is not held locally, the controller starts a long array access. At the end of it the whole page is copied into a local buffer. Reads that stay inside the buffered page are then answered after a much shorter delay. All delays are counted in system clock cycles.

The two lowest address bits choose the word within the page. They are not held by the latch: they are used live, so the host can step through the words of a page just by changing them. The upper address bits are taken only when the latch input is high. The controller answers only while the chip is enabled and the asynchronous mode bit from the configuration register is set. Output enable only gates what is shown on the port. The array is a behavioural model. Each word holds a value computed from its own address.

Top module: `page_read_ctrl`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 0 and no page is held.
- R2: A latch with `async_mode`=1 and `chip_en_n`=0, whose page (address bits above 1:0) is not the held page or arrives when no page is held, makes `rd_valid` rise T_LONG cycles (default 6) after the clock edge that samples the latch. The data is then the word at full address A, equal to (A*16'h9E37 + 16'h1234) truncated to 16 bits.
- R3: A change of address bits 1:0 while a page is held and no fetch is running takes effect without a latch. `rd_valid` drops in the same cycle as the change and returns T_SHORT cycles (default 2) after the edge that samples the new value. The data is then the newly selected word of the held page.
- R4: Latching the page that is already held gives `rd_valid` after T_SHORT cycles, not T_LONG.
- R5: Latching a different page drops the held page and restores the T_LONG delay.
- R6: While `out_en_n` is 1, `rd_data` is 0 and `rd_valid` is 0, but a fetch in progress still completes. If the fetch has finished, lowering `out_en_n` gives valid data in the same cycle.
- R7: `chip_en_n` at 1 discards the held page and cancels any fetch. The next read of any page takes T_LONG cycles.
- R8: With `async_mode` at 0, latches are ignored and `rd_valid` stays 0, and the held page is kept.
- R9: A change of bits 1:0 during a fetch, including in the cycle the fetch completes, adds no short delay. Valid data for the current word appears when the fetch ends.
- R10: `rd_data` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW (8) | Read address; bits 1:0 select the word and are used live |
| addr_latch | input | 1 | High for a cycle to capture the page part of `addr` |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| async_mode | input | 1 | Configuration bit that enables asynchronous reads |
| rd_data | output | DW (16) | Selected word, 0 when not valid |
| rd_valid | output | 1 | High while `rd_data` holds the addressed word |

## Verification
Two events can collide: the end of a long page fetch and a change of the live word select. The bench times a word-select change so that it lands exactly on the completing edge of a fetch, and another one in the middle of a fetch. It then requires valid data one and T_LONG-2 cycles later respectively, with no short delay added. A second overlap is output enable held high across a fetch. This is judged by valid data appearing in the same cycle output enable falls.

// File: rtl/prc_pkg.sv
package prc_pkg;
    parameter int ADDR_W     = 8;
    parameter int DATA_W     = 16;
    parameter int PAGE_WORDS = 4;
    parameter int SEL_W      = $clog2(PAGE_WORDS);
    parameter int MEM_MUL    = 32'h0000_9E37;
    parameter int MEM_ADD    = 32'h0000_1234;
endpackage

// File: rtl/page_array.sv
module page_array
    import prc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic [AW-SEL_W-1:0]                 page,
    output logic [PAGE_WORDS-1:0][DW-1:0]       words
);
    localparam logic [DW-1:0] MUL_V = DW'(MEM_MUL);
    localparam logic [DW-1:0] ADD_V = DW'(MEM_ADD);

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
        logic [AW-1:0] full_a;
        assign full_a   = {page, SEL_W'(i)};
        assign words[i] = DW'(DW'(full_a) * MUL_V + ADD_V);
    end
endmodule

// File: rtl/lat_timer.sv
module lat_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] load_val,
    output logic          busy,
    output logic          expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (stop)
            cnt_d = '0;
        else if (start)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy   = (cnt_q != '0);
    assign expire = (cnt_q == CW'(1)) && !start && !stop;
endmodule

// File: rtl/page_read_ctrl.sv
module page_read_ctrl
    import prc_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int T_LONG  = 6,
    parameter int T_SHORT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          addr_latch,
    input  logic          chip_en_n,
    input  logic          out_en_n,
    input  logic          async_mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int PW   = AW - SEL_W;
    localparam int TMAX = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LONG_V  = CW'(T_LONG);
    localparam logic [CW-1:0] SHORT_V = CW'(T_SHORT);

    typedef struct packed {
        logic [PW-1:0]                   pg;
        logic                            pv;
        logic [SEL_W-1:0]                ws;
        logic [PAGE_WORDS-1:0][DW-1:0]   pbuf;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0]    addr_pg;
    logic [SEL_W-1:0] addr_ws;
    logic ce, act, hit, lat, miss_lat, hit_lat, wchg;
    logic long_start, long_stop, long_busy, long_expire;
    logic short_start, short_stop, short_busy, short_expire;
    logic [PAGE_WORDS-1:0][DW-1:0] arr_words;

    assign addr_pg  = addr[AW-1:SEL_W];
    assign addr_ws  = addr[SEL_W-1:0];
    assign ce       = !chip_en_n;
    assign act      = ce && async_mode;
    assign hit      = st_q.pv && (addr_pg == st_q.pg);
    assign lat      = act && addr_latch;
    assign miss_lat = lat && !hit;
    assign hit_lat  = lat && hit;
    assign wchg     = (addr_ws != st_q.ws);

    assign long_start  = miss_lat;
    assign long_stop   = !ce;
    assign short_stop  = !ce || miss_lat;
    assign short_start = act && st_q.pv && !long_busy && (wchg || hit_lat);

    lat_timer #(.CW(CW)) u_long (
        .clk(clk), .rst_n(rst_n), .start(long_start), .stop(long_stop),
        .load_val(LONG_V), .busy(long_busy), .expire(long_expire)
    );

    lat_timer #(.CW(CW)) u_short (
        .clk(clk), .rst_n(rst_n), .start(short_start), .stop(short_stop),
        .load_val(SHORT_V), .busy(short_busy), .expire(short_expire)
    );

    page_array #(.AW(AW), .DW(DW)) u_arr (
        .page(st_q.pg), .words(arr_words)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ws = addr_ws;
        if (miss_lat)
            st_d.pg = addr_pg;
        if (!ce || miss_lat)
            st_d.pv = 1'b0;
        else if (long_expire) begin
            st_d.pv   = 1'b1;
            st_d.pbuf = arr_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = act && !out_en_n && st_q.pv && !long_busy
                      && !short_busy && !wchg;
    assign rd_data  = rd_valid ? st_q.pbuf[addr_ws] : '0;

    logic unused_ok;
    assign unused_ok = short_expire;

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        long_expire && ce |=> st_q.pv);
    p_word_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act && st_q.pv && !long_busy && wchg && !miss_lat |=> short_busy && !rd_valid);
    p_new_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_lat |=> long_busy && !st_q.pv);
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_valid && rd_data == '0);
    p_ce_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |=> !st_q.pv && !long_busy);
    p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |-> !rd_valid);
    p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode && ce && st_q.pv |=> st_q.pv && $stable(st_q.pg));
endmodule

// File: tb/page_read_ctrl_tb_top.sv
module page_read_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TL = 6;
    localparam int TS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          addr_latch = 1'b0;
    logic          chip_en_n = 1'b0;
    logic          out_en_n = 1'b0;
    logic          async_mode = 1'b1;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    page_read_ctrl #(.AW(AW), .DW(DW), .T_LONG(TL), .T_SHORT(TS)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .addr_latch(addr_latch),
        .chip_en_n(chip_en_n), .out_en_n(out_en_n), .async_mode(async_mode),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [15:0] exp_word(input logic [AW-1:0] a);
        logic [15:0] t;
        t = {8'h00, a};
        return t * 16'h9E37 + 16'h1234;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_latch(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a;
        addr_latch = 1'b1;
        @(negedge clk);
        addr_latch = 1'b0;
        #1;
    endtask

    task automatic count_valid(output int n);
        n = 0;
        while (!rd_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_word(input logic [1:0] w);
        @(negedge clk);
        addr[1:0] = w;
        #1;
    endtask

    task automatic t_reset;
        chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
        chk(rd_data == '0, "R1 data", rd_data, 0);
    endtask

    task automatic t_miss;
        int n;
        do_latch(8'h35);
        count_valid(n);
        chk(n == TL, "R2 latency", n, TL);
        chk(rd_data == exp_word(8'h35), "R2 data", rd_data, exp_word(8'h35));
    endtask

    task automatic t_words;
        int n;
        for (int w = 0; w < 4; w++) begin
            if (w == 1) continue;
            set_word(2'(w));
            chk(rd_valid == 1'b0, "R3 drop", rd_valid, 0);
            chk(rd_data == '0, "R10 data zero", rd_data, 0);
            count_valid(n);
            chk(n == TS + 1, "R3 latency", n, TS + 1);
            chk(rd_data == exp_word({6'h0D, 2'(w)}), "R3 data", rd_data,
                exp_word({6'h0D, 2'(w)}));
        end
    endtask

    task automatic t_hit;
        int n;
        do_latch({6'h0D, 2'd2});
        count_valid(n);
        chk(n == TS, "R4 latency", n, TS);
        chk(rd_data == exp_word(8'h36), "R4 data", rd_data, exp_word(8'h36));
    endtask

    task automatic t_new_page;
        int n;
        do_latch(8'hA1);
        chk(rd_valid == 1'b0, "R5 drop", rd_valid, 0);
        count_valid(n);
        chk(n == TL, "R5 latency", n, TL);
        chk(rd_data == exp_word(8'hA1), "R5 data", rd_data, exp_word(8'hA1));
    endtask

    task automatic t_oe;
        bit clean = 1'b1;
        @(negedge clk);
        out_en_n = 1'b1;
        do_latch(8'h42);
        for (int i = 0; i < TL + 2; i++) begin
            if (rd_valid || rd_data != '0) clean = 1'b0;
            @(negedge clk);
        end
        chk(clean, "R6 gated", clean, 1);
        out_en_n = 1'b0;
        #1;
        chk(rd_valid == 1'b1, "R6 fetch kept", rd_valid, 1);
        chk(rd_data == exp_word(8'h42), "R6 data", rd_data, exp_word(8'h42));
    endtask

    task automatic t_ce;
        int n;
        bit clean = 1'b1;
        @(negedge clk);
        chip_en_n = 1'b1;
        @(negedge clk);
        chip_en_n = 1'b0;
        #1;
        chk(rd_valid == 1'b0, "R7 page cleared", rd_valid, 0);
        do_latch(8'h42);
        count_valid(n);
        chk(n == TL, "R7 relatch long", n, TL);
        do_latch(8'h90);
        @(negedge clk);
        chip_en_n = 1'b1;
        @(negedge clk);
        chip_en_n = 1'b0;
        for (int i = 0; i < TL + 3; i++) begin
            @(negedge clk);
            if (rd_valid) clean = 1'b0;
        end
        chk(clean, "R7 fetch cancelled", clean, 1);
    endtask

    task automatic t_mode;
        int n;
        do_latch(8'h5C);
        count_valid(n);
        @(negedge clk);
        async_mode = 1'b0;
        #1;
        chk(rd_valid == 1'b0, "R8 valid off", rd_valid, 0);
        do_latch(8'hE0);
        repeat (TL + 2) @(negedge clk);
        async_mode = 1'b1;
        #1;
        chk(rd_valid == 1'b1, "R8 page kept", rd_valid, 1);
        chk(rd_data == exp_word(8'h5C), "R8 latch ignored", rd_data, exp_word(8'h5C));
    endtask

    task automatic t_overlap;
        int n;
        do_latch(8'h70);
        repeat (TL - 1) @(negedge clk);
        addr[1:0] = 2'd3;
        #1;
        count_valid(n);
        chk(n == 1, "R9 end-edge latency", n, 1);
        chk(rd_data == exp_word(8'h73), "R9 end-edge data", rd_data, exp_word(8'h73));
        do_latch(8'h14);
        repeat (2) @(negedge clk);
        addr[1:0] = 2'd2;
        #1;
        count_valid(n);
        chk(n == TL - 2, "R9 mid latency", n, TL - 2);
        chk(rd_data == exp_word(8'h16), "R9 mid data", rd_data, exp_word(8'h16));
    endtask

    initial begin
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_miss();
        t_words();
        t_hit();
        t_new_page();
        t_oe();
        t_ce();
        t_mode();
        t_overlap();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule